// File: doc/BRIEF.md
# Register-Pair ALU with Flag Register

This block holds a machine's sixteen 8-bit general registers and carries out the register-to-register arithmetic and logic group of its instruction set. A caller pulses `start` for one cycle with a 4-bit sub-opcode and two register indices, x and y. In that cycle the block reads both registers. At the next clock edge it writes the result back to register x and, for the arithmetic and shift operations, writes a 0/1 flag into the highest register (index 15). `done` is high in the cycle after `start`.

The highest register is both an ordinary operand and the flag destination. The order of the writes therefore decides what a register holds when x names it. The flag is always computed from the operand values read before the operation writes anything. Other instruction groups of the machine fill registers through a plain load port. A debug port reads any register combinationally.

Top module: `regpair_alu`

## Requirements
- R1: Sub-opcode 0 copies Vy into Vx. Sub-opcodes 1, 2 and 3 store Vx OR Vy, Vx AND Vy and Vx XOR Vy into Vx.
- R2: Sub-opcode 4 stores (Vx + Vy) mod 256 into Vx and sets V15 to 1 when the sum exceeds 255, else to 0.
- R3: Sub-opcode 5 stores (Vx − Vy) mod 256 into Vx and sets V15 to 1 when Vx ≥ Vy, else to 0.
- R4: Sub-opcode 7 stores (Vy − Vx) mod 256 into Vx and sets V15 to 1 when Vy ≥ Vx, else to 0.
- R5: Sub-opcode 6 stores Vx shifted right by one into Vx and sets V15 to the old bit 0 of Vx.
- R6: Sub-opcode 14 (hex E) stores Vx shifted left by one into Vx and sets V15 to the old bit 7 of Vx.
- R7: When a flag-setting operation has x = 15, V15 ends up holding the flag value, not the result.
- R8: The flag is computed from the register values as they were before the operation, also when y = 15 or x = y.
- R9: Sub-opcodes 8 to 13 and 15 change no register, and `done` still follows.
- R10: `done` is high exactly in the cycle after a cycle with `start` high, and low otherwise.
- R11: Reset clears all sixteen registers to 0 and drives `done` low.
- R12: With `load_en` high and `start` low, `load_data` is written into register `load_idx` at the clock edge. A load is ignored in a cycle with `start` high.
- R13: Sub-opcodes 0 to 3 leave V15 unchanged unless x = 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches an operation |
| sub_op | input | 4 | Operation selector |
| idx_x | input | 4 | Index of the destination and first operand |
| idx_y | input | 4 | Index of the second operand |
| done | output | 1 | High in the cycle after `start` |
| load_en | input | 1 | Register load strobe |
| load_idx | input | 4 | Register written by a load |
| load_data | input | 8 | Value written by a load |
| dbg_idx | input | 4 | Register selected for the debug read |
| dbg_data | output | 8 | Current value of the selected register |

## Verification
Every sub-opcode is run on x = 1, y = 2 with operand pairs drawn from values around 0, the sign boundary 0x7F/0x80/0x81 and 0xFE/0xFF. These pairs tell carry from no carry, borrow from equality, and which bit each shift moves out. V15 is preloaded with 0xA5, so a stray flag write is visible for both the flag-free and the undefined sub-opcodes. Separate cases put the flag register in the x and y slots and use x = y. These cases separate the write order from the operand snapshot. A load issued together with `start` shows that the load is dropped.

// File: rtl/regpair_alu_pkg.sv
package regpair_alu_pkg;

    typedef enum logic [3:0] {
        OP_MOV  = 4'h0,
        OP_OR   = 4'h1,
        OP_AND  = 4'h2,
        OP_XOR  = 4'h3,
        OP_ADD  = 4'h4,
        OP_SUB  = 4'h5,
        OP_SHR  = 4'h6,
        OP_RSUB = 4'h7,
        OP_SHL  = 4'hE
    } alu_op_e;

    typedef struct packed {
        logic res_we;
        logic flag_we;
        logic flag;
    } alu_ctl_t;

    function automatic logic op_is_defined(input logic [3:0] op);
        return (op <= 4'h7) || (op == 4'hE);
    endfunction

    function automatic logic op_sets_flag(input logic [3:0] op);
        return (op >= 4'h4 && op <= 4'h7) || (op == 4'hE);
    endfunction

endpackage

// File: rtl/regpair_alu_core.sv
module regpair_alu_core
    import regpair_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output alu_ctl_t          ctl
);

    logic [DATA_W:0] wide;
    alu_op_e         op_e;

    always_comb begin
        op_e        = alu_op_e'(op);
        wide        = '0;
        res         = opa;
        ctl.res_we  = op_is_defined(op);
        ctl.flag_we = op_sets_flag(op);
        ctl.flag    = 1'b0;
        case (op_e)
            OP_MOV:  res = opb;
            OP_OR:   res = opa | opb;
            OP_AND:  res = opa & opb;
            OP_XOR:  res = opa ^ opb;
            OP_ADD: begin
                wide     = {1'b0, opa} + {1'b0, opb};
                res      = wide[DATA_W-1:0];
                ctl.flag = wide[DATA_W];
            end
            OP_SUB: begin
                res      = opa - opb;
                ctl.flag = (opa >= opb);
            end
            OP_RSUB: begin
                res      = opb - opa;
                ctl.flag = (opb >= opa);
            end
            OP_SHR: begin
                res      = opa >> 1;
                ctl.flag = opa[0];
            end
            OP_SHL: begin
                res      = opa << 1;
                ctl.flag = opa[DATA_W-1];
            end
            default: res = opa;
        endcase
    end

endmodule

// File: rtl/regpair_alu_regfile.sv
module regpair_alu_regfile #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4,
    parameter int FLAG_IDX = 15
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [IDX_W-1:0]           rda_idx,
    input  logic [IDX_W-1:0]           rdb_idx,
    input  logic [IDX_W-1:0]           rdd_idx,
    output logic [DATA_W-1:0]          rda_data,
    output logic [DATA_W-1:0]          rdb_data,
    output logic [DATA_W-1:0]          rdd_data,
    input  logic                       res_we,
    input  logic [IDX_W-1:0]           res_idx,
    input  logic [DATA_W-1:0]          res_data,
    input  logic                       flag_we,
    input  logic                       flag_bit,
    input  logic                       ld_we,
    input  logic [IDX_W-1:0]           ld_idx,
    input  logic [DATA_W-1:0]          ld_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [DATA_W-1:0] flag_word;

    assign flag_word = {{(DATA_W-1){1'b0}}, flag_bit};

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (flag_we && (g == FLAG_IDX)) begin
                // flag write lands after the result write: it wins on x == FLAG_IDX
                regs[g] <= flag_word;
            end else if (res_we && (res_idx == IDX_W'(g))) begin
                regs[g] <= res_data;
            end else if (ld_we && (ld_idx == IDX_W'(g))) begin
                regs[g] <= ld_data;
            end
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    assign rda_data = regs[rda_idx];
    assign rdb_data = regs[rdb_idx];
    assign rdd_data = regs[rdd_idx];

endmodule

// File: rtl/regpair_alu.sv
module regpair_alu
    import regpair_alu_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int FLAG_IDX = NUM_REGS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        sub_op,
    input  logic [IDX_W-1:0]  idx_x,
    input  logic [IDX_W-1:0]  idx_y,
    output logic              done,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [DATA_W-1:0] load_data,
    input  logic [IDX_W-1:0]  dbg_idx,
    output logic [DATA_W-1:0] dbg_data
);

    logic [DATA_W-1:0]          rd_x;
    logic [DATA_W-1:0]          rd_y;
    logic [DATA_W-1:0]          alu_res;
    alu_ctl_t                   alu_ctl;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic                       done_q;

    regpair_alu_core #(.DATA_W(DATA_W)) core_i (
        .op  (sub_op),
        .opa (rd_x),
        .opb (rd_y),
        .res (alu_res),
        .ctl (alu_ctl)
    );

    regpair_alu_regfile #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W),
        .FLAG_IDX(FLAG_IDX)
    ) rf_i (
        .clk      (clk),
        .rst      (rst),
        .rda_idx  (idx_x),
        .rdb_idx  (idx_y),
        .rdd_idx  (dbg_idx),
        .rda_data (rd_x),
        .rdb_data (rd_y),
        .rdd_data (dbg_data),
        .res_we   (start & alu_ctl.res_we),
        .res_idx  (idx_x),
        .res_data (alu_res),
        .flag_we  (start & alu_ctl.flag_we),
        .flag_bit (alu_ctl.flag),
        .ld_we    (load_en & ~start),
        .ld_idx   (load_idx),
        .ld_data  (load_data),
        .regs_flat(regs_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= start;
    end

    assign done = done_q;

endmodule

// File: rtl/regpair_alu_chk.sv
module regpair_alu_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4,
    parameter int FLAG_IDX = 15
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start,
    input logic [3:0]                 sub_op,
    input logic                       done,
    input logic [DATA_W-1:0]          rd_a,
    input logic [DATA_W-1:0]          rd_b,
    input logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    logic [DATA_W:0]   sum_w;
    logic [DATA_W-1:0] flag_reg;
    logic              undef_op;

    assign sum_w    = {1'b0, rd_a} + {1'b0, rd_b};
    assign flag_reg = regs_flat[FLAG_IDX*DATA_W +: DATA_W];
    assign undef_op = (sub_op >= 4'h8) && (sub_op != 4'hE);

    assert_done_after_start_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    assert_done_needs_start_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));

    assert_add_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (start && sub_op == 4'h4) |=>
        flag_reg == {{(DATA_W-1){1'b0}}, $past(sum_w[DATA_W])});

    assert_sub_noborrow_R3: assert property (@(posedge clk) disable iff (rst)
        (start && sub_op == 4'h5) |=>
        flag_reg == {{(DATA_W-1){1'b0}}, $past(rd_a >= rd_b)});

    assert_shr_outbit_R5: assert property (@(posedge clk) disable iff (rst)
        (start && sub_op == 4'h6) |=>
        flag_reg == {{(DATA_W-1){1'b0}}, $past(rd_a[0])});

    assert_undef_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (start && undef_op) |=> $stable(regs_flat));

endmodule

bind regpair_alu regpair_alu_chk #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W),
    .FLAG_IDX(FLAG_IDX)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sub_op   (sub_op),
    .done     (done),
    .rd_a     (rd_x),
    .rd_b     (rd_y),
    .regs_flat(regs_flat)
);

// File: tb/regpair_alu_tb_top.sv
module regpair_alu_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [3:0] sub_op;
    logic [3:0] idx_x;
    logic [3:0] idx_y;
    logic       done;
    logic       load_en;
    logic [3:0] load_idx;
    logic [7:0] load_data;
    logic [3:0] dbg_idx;
    logic [7:0] dbg_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regpair_alu dut_i (
        .clk(clk), .rst(rst), .start(start), .sub_op(sub_op),
        .idx_x(idx_x), .idx_y(idx_y), .done(done),
        .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input int val);
        @(negedge clk);
        load_en   = 1'b1;
        load_idx  = 4'(idx);
        load_data = 8'(val);
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic run_op(input int op, input int x, input int y, input string req);
        @(negedge clk);
        start  = 1'b1;
        sub_op = 4'(op);
        idx_x  = 4'(x);
        idx_y  = 4'(y);
        @(negedge clk);
        start  = 1'b0;
        chk({req, " done"}, int'(done), 1);
    endtask

    task automatic rd(input int idx, output int val);
        dbg_idx = 4'(idx);
        #1;
        val = int'(dbg_data);
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0, 1, 2, 3: return "R1";
            4:          return "R2";
            5:          return "R3";
            6:          return "R5";
            7:          return "R4";
            14:         return "R6";
            default:    return "R9";
        endcase
    endfunction

    // expected result and flag from the requirement arithmetic
    function automatic void model(input int op, input int a, input int b, input int f,
                                  output int r, output int nf);
        r  = a;
        nf = f;
        case (op)
            0: r = b;
            1: r = a | b;
            2: r = a & b;
            3: r = a ^ b;
            4: begin r = (a + b) % 256;       nf = (a + b > 255) ? 1 : 0; end
            5: begin r = (a - b + 256) % 256; nf = (a >= b) ? 1 : 0; end
            6: begin r = a / 2;               nf = a % 2; end
            7: begin r = (b - a + 256) % 256; nf = (b >= a) ? 1 : 0; end
            14: begin r = (a * 2) % 256;      nf = a / 128; end
            default: ;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int v, er, ef;
        int vals[8] = '{0, 1, 2, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};
        rst = 1'b1; start = 1'b0; load_en = 1'b0;
        sub_op = '0; idx_x = '0; idx_y = '0; load_idx = '0; load_data = '0; dbg_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk("R11 done", int'(done), 0);
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            chk("R11 reg", v, 0);
        end

        // R12 plain load
        load(9, 8'h3C);
        rd(9, v);
        chk("R12 load", v, 8'h3C);

        // sweep: every sub-opcode over the operand grid, x=1 y=2
        for (int op = 0; op < 16; op++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    load(1, vals[ia]);
                    load(2, vals[ib]);
                    load(15, 8'hA5);
                    run_op(op, 1, 2, tag_of(op));
                    model(op, vals[ia], vals[ib], 8'hA5, er, ef);
                    rd(1, v);
                    chk({tag_of(op), " result"}, v, er);
                    rd(15, v);
                    chk({tag_of(op), (op <= 3) ? " R13 flag kept" : " flag"}, v, ef);
                    rd(2, v);
                    chk({tag_of(op), " y untouched"}, v, vals[ib]);
                end
            end
        end

        // R10 done drops after one cycle
        @(negedge clk);
        chk("R10 done low", int'(done), 0);

        // R7 x = 15: flag overrides result
        load(15, 8'h90); load(3, 8'h90);
        run_op(4, 15, 3, "R7");
        rd(15, v); chk("R7 add x=15", v, 1);
        load(15, 5); load(3, 9);
        run_op(5, 15, 3, "R7");
        rd(15, v); chk("R7 sub x=15", v, 0);
        load(15, 8'h80);
        run_op(14, 15, 3, "R7");
        rd(15, v); chk("R7 shl x=15", v, 1);
        load(15, 8'h40);
        run_op(1, 15, 3, "R13");
        rd(15, v); chk("R13 or x=15", v, 8'h49);

        // R8 flag from pre-write operands
        load(2, 8'h80); load(15, 8'h80);
        run_op(4, 2, 15, "R8");
        rd(2, v);  chk("R8 y=15 result", v, 0);
        rd(15, v); chk("R8 y=15 flag", v, 1);
        load(4, 200);
        run_op(4, 4, 4, "R8");
        rd(4, v);  chk("R8 x=y result", v, 8'h90);
        rd(15, v); chk("R8 x=y flag", v, 1);
        load(5, 7);
        run_op(7, 5, 5, "R8");
        rd(5, v);  chk("R8 rsub x=y result", v, 0);
        rd(15, v); chk("R4 rsub x=y flag", v, 1);

        // R12 load ignored while start is high
        load(6, 8'h11);
        @(negedge clk);
        start = 1'b1; sub_op = 4'h9; idx_x = 4'd6; idx_y = 4'd6;
        load_en = 1'b1; load_idx = 4'd6; load_data = 8'h77;
        @(negedge clk);
        start = 1'b0; load_en = 1'b0;
        chk("R9 done on undefined", int'(done), 1);
        rd(6, v); chk("R12 load dropped", v, 8'h11);

        // R11 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(6, v);  chk("R11 reg after reset", v, 0);
        rd(15, v); chk("R11 flag after reset", v, 0);
        chk("R11 done after reset", int'(done), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule